// File: doc/BRIEF.md
# Descriptor-Driven DRAM Timing Decoder

This block turns the bytes of a memory module's descriptor into the packed configuration values a DRAM controller needs. A pulse on `start` makes it read a fixed list of descriptor bytes. It reads them one at a time through a byte-fetch port: it presents an address, holds a request, and waits for a valid strobe that carries the data. When every byte has arrived, it derives a reference cycle value from the module's minimum clock period. It then sizes each timing parameter in whole clocks against small multiples of that reference, and picks the lowest CAS latency the part supports at that speed.

The results are an address-map type byte, the first-rank size and the cumulative rank end in 32 MB units, one combined timing byte, and a DRAM clock-select code. They are presented together and marked by `done`, which stays high until the next accepted `start`. If a fetch gets no answer, the run stops with `err` set and the outputs hold their defaults.

Top module: `spd_timing_decoder`

## Requirements
- R1: The minimum cycle-time byte (descriptor offset 9) selects a reference of 0x14 and clock code 0x85 when it is at most 0x50, a reference of 0x18 and clock code 0x81 when it is at most 0x60, and a reference of 0x1E and clock code 0x80 otherwise.
- R2: When the latency byte (offset 18) has bit 4 set, the CAS field (timing bits 5:4) starts at 3. It becomes 2 if bit 3 is set and the byte at offset 23 is at most the reference. It then becomes 1 if bit 2 is set and the byte at offset 25 is at most the reference.
- R3: When bit 4 of the latency byte is clear, the CAS field is 2. It becomes 1 if bit 2 is set and the byte at offset 23 is at most the reference.
- R4: Timing bits 1:0 take the row-precharge byte (offset 27) and bits 3:2 the RAS-to-CAS byte (offset 29). Each field is 3 when the value is at least 5×ref, otherwise 2 when at least 4×ref, otherwise 1 when at least 3×ref, otherwise 0.
- R5: Timing bits 7:6 take the active-to-precharge byte (offset 30). The field is 3, 2 or 1 at thresholds of 9×ref, 8×ref and 7×ref, and 0 below 7×ref.
- R6: The map byte is 0 unless the internal-bank byte (offset 17) equals 4. When it does, bit 7 is set if the row byte (offset 3) is at least 13 and the width byte (offset 13) is not 4. The column byte (offset 4) adds 0x60 for 10, 11 or 12, 0x40 for 9 and 0x20 for 8.
- R7: The rank size comes from the density byte (offset 31). The first set bit in the priority order 1, 0, 7, 6, 5, 4, 3 gives 0x40, 0x20, 0x10, 0x08, 0x04, 0x02 or 0x01 in that order. A byte with none of these bits set gives 0x01.
- R8: The rank end equals the rank size shifted left by one when the rank-count byte (offset 5) equals 2, and equals the rank size otherwise.
- R9: Descriptor bytes are fetched once each, in the order 9, 18, 23, 25, 27, 29, 30, 17, 3, 13, 4, 31, 5. The address is held with the request high until the valid strobe arrives.
- R10: If no valid strobe arrives within TIMEOUT request cycles, the run ends with `err` and `done` high, the request low, and the outputs at their defaults: map 0, rank size 0x01, rank end 0x01, timing 0x00, clock code 0x80.
- R11: After reset, and after any accepted start, `done` and `err` are low and the outputs are at their defaults. `done` and the outputs then hold until the next accepted start. A `start` that arrives while a run is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a decode run (accepted only when idle or finished) |
| fetch_req | output | 1 | Byte fetch request |
| fetch_addr | output | 8 | Descriptor byte offset being requested |
| fetch_valid | input | 1 | Fetch data valid strobe |
| fetch_data | input | 8 | Fetched descriptor byte |
| done | output | 1 | Outputs valid, run finished |
| err | output | 1 | Run ended by fetch timeout |
| map_type | output | 8 | Address-map type byte |
| rank0_size | output | 8 | First rank size, 32 MB units |
| rank_end | output | 8 | Cumulative end of later ranks, 32 MB units |
| timing_cfg | output | 8 | Packed tRAS, CAS, tRCD, tRP codes |
| clk_sel | output | 8 | DRAM clock select code |

## Verification
A fault in the fetch sequencer shows at the fetch port within a cycle or two: an address out of order, a skipped or repeated offset, or a request that drops before its strobe. A fault in the iterative comparator or its step counter leaves the fetch sequence intact. It shows only in the timing byte at `done`, as a field one code off near a threshold. For that reason the sweeps place the timing values exactly on, and one below, each multiple of the reference. A wrong reference value shows as a combined error in the clock code and in every timing field of the same run.

// File: rtl/spd_dec_pkg.sv
package spd_dec_pkg;

  localparam int NBYTES   = 13;
  localparam int IX_TCK   = 0;
  localparam int IX_CL    = 1;
  localparam int IX_TCK2  = 2;
  localparam int IX_TCK3  = 3;
  localparam int IX_TRP   = 4;
  localparam int IX_TRCD  = 5;
  localparam int IX_TRAS  = 6;
  localparam int IX_BANKS = 7;
  localparam int IX_ROWS  = 8;
  localparam int IX_WIDTH = 9;
  localparam int IX_COLS  = 10;
  localparam int IX_DENS  = 11;
  localparam int IX_RANKS = 12;

  // fetch slot -> descriptor offset
  function automatic logic [7:0] desc_addr(input logic [7:0] ix);
    case (ix)
      8'd0:    desc_addr = 8'd9;
      8'd1:    desc_addr = 8'd18;
      8'd2:    desc_addr = 8'd23;
      8'd3:    desc_addr = 8'd25;
      8'd4:    desc_addr = 8'd27;
      8'd5:    desc_addr = 8'd29;
      8'd6:    desc_addr = 8'd30;
      8'd7:    desc_addr = 8'd17;
      8'd8:    desc_addr = 8'd3;
      8'd9:    desc_addr = 8'd13;
      8'd10:   desc_addr = 8'd4;
      8'd11:   desc_addr = 8'd31;
      default: desc_addr = 8'd5;
    endcase
  endfunction

  // shift-and-add product of a byte and a small factor
  function automatic logic [11:0] mul_small(input logic [7:0] a, input logic [3:0] k);
    logic [11:0] acc;
    acc = '0;
    for (int i = 0; i < 4; i++)
      if (k[i]) acc = acc + ({4'b0, a} << i);
    return acc;
  endfunction

  function automatic logic [7:0] cycle_ref(input logic [7:0] tck);
    if (tck <= 8'h50)      cycle_ref = 8'h14;
    else if (tck <= 8'h60) cycle_ref = 8'h18;
    else                   cycle_ref = 8'h1E;
  endfunction

  function automatic logic [7:0] clock_code(input logic [7:0] tck);
    if (tck <= 8'h50)      clock_code = 8'h85;
    else if (tck <= 8'h60) clock_code = 8'h81;
    else                   clock_code = 8'h80;
  endfunction

  function automatic logic [1:0] cas_code(input logic [7:0] cl, input logic [7:0] t2,
                                          input logic [7:0] t3, input logic [7:0] rv);
    logic [1:0] c;
    if (cl[4]) begin
      c = 2'd3;
      if (cl[3] && t2 <= rv) c = 2'd2;
      if (cl[2] && t3 <= rv) c = 2'd1;
    end else begin
      c = 2'd2;
      if (cl[2] && t2 <= rv) c = 2'd1;
    end
    return c;
  endfunction

  function automatic logic [7:0] map_code(input logic [7:0] banks, input logic [7:0] rows,
                                          input logic [7:0] width, input logic [7:0] cols);
    logic [7:0] m;
    m = '0;
    if (banks == 8'd4) begin
      if (rows >= 8'd13 && width != 8'd4) m = 8'h80;
      if (cols >= 8'd10 && cols <= 8'd12) m = m | 8'h60;
      else if (cols == 8'd9)              m = m | 8'h40;
      else if (cols == 8'd8)              m = m | 8'h20;
    end
    return m;
  endfunction

  function automatic logic [7:0] dens_size(input logic [7:0] d);
    if (d[1])      dens_size = 8'h40;
    else if (d[0]) dens_size = 8'h20;
    else if (d[7]) dens_size = 8'h10;
    else if (d[6]) dens_size = 8'h08;
    else if (d[5]) dens_size = 8'h04;
    else if (d[4]) dens_size = 8'h02;
    else           dens_size = 8'h01;
  endfunction

endpackage

// File: rtl/spd_fetch_seq.sv
module spd_fetch_seq
  import spd_dec_pkg::*;
#(
  parameter int NB      = NBYTES,
  parameter int TIMEOUT = 16,
  localparam int IW     = $clog2(NB),
  localparam int CW     = $clog2(TIMEOUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          fetch_valid,
  input  logic [7:0]    fetch_data,
  output logic          fetch_req,
  output logic [7:0]    fetch_addr,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic          fin,
  output logic          tmo
);
  logic          active;
  logic [IW-1:0] idx;
  logic [CW-1:0] cnt;
  logic          wait_expire;
  logic          last_slot;

  assign wait_expire = active && !fetch_valid && (cnt == CW'(TIMEOUT - 1));
  assign last_slot   = (idx == IW'(NB - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      cnt    <= '0;
      fin    <= 1'b0;
      tmo    <= 1'b0;
    end else begin
      fin <= 1'b0;
      tmo <= 1'b0;
      if (go) begin
        active <= 1'b1;
        idx    <= '0;
        cnt    <= '0;
      end else if (active) begin
        if (fetch_valid) begin
          cnt <= '0;
          if (last_slot) begin
            active <= 1'b0;
            fin    <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end else if (wait_expire) begin
          active <= 1'b0;
          tmo    <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign fetch_req  = active;
  assign fetch_addr = desc_addr(8'(idx));
  assign wr_en      = active && fetch_valid;
  assign wr_idx     = idx;
  assign wr_data    = fetch_data;

  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    active && !fetch_valid && !wait_expire && !go |=> fetch_req && $stable(fetch_addr));

  p_timeout_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |-> !fetch_req);
endmodule

// File: rtl/spd_quantizer.sv
module spd_quantizer
  import spd_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] ref_val,
  input  logic [7:0] v_trp,
  input  logic [7:0] v_trcd,
  input  logic [7:0] v_tras,
  output logic [1:0] c_trp,
  output logic [1:0] c_trcd,
  output logic [1:0] c_tras,
  output logic       q_done
);
  logic        busy;
  logic [1:0]  fi;
  logic [1:0]  step;
  logic [3:0]  k;
  logic [7:0]  val_sel;
  logic [11:0] thr;
  logic        cmp_hit;
  logic        field_end;
  logic [1:0]  code_now;

  // one comparison per clock: factor walks 5,4,3 (or 9,8,7)
  assign k         = (fi == 2'd2) ? (4'd9 - {2'b0, step}) : (4'd5 - {2'b0, step});
  assign val_sel   = (fi == 2'd0) ? v_trp : (fi == 2'd1) ? v_trcd : v_tras;
  assign thr       = mul_small(ref_val, k);
  assign cmp_hit   = busy && ({4'b0, val_sel} >= thr);
  assign field_end = busy && (cmp_hit || step == 2'd2);
  assign code_now  = cmp_hit ? (2'd3 - step) : 2'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      fi     <= '0;
      step   <= '0;
      c_trp  <= '0;
      c_trcd <= '0;
      c_tras <= '0;
      q_done <= 1'b0;
    end else begin
      q_done <= 1'b0;
      if (go) begin
        busy   <= 1'b1;
        fi     <= '0;
        step   <= '0;
        c_trp  <= '0;
        c_trcd <= '0;
        c_tras <= '0;
      end else if (busy) begin
        if (field_end) begin
          case (fi)
            2'd0:    c_trp  <= code_now;
            2'd1:    c_trcd <= code_now;
            default: c_tras <= code_now;
          endcase
          step <= '0;
          if (fi == 2'd2) begin
            busy   <= 1'b0;
            q_done <= 1'b1;
          end else begin
            fi <= fi + 1'b1;
          end
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end

  p_step_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> step != 2'd3 && fi != 2'd3);

  p_done_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    q_done |-> $past(busy) && !busy);
endmodule

// File: rtl/spd_timing_decoder.sv
module spd_timing_decoder
  import spd_dec_pkg::*;
#(
  parameter int TIMEOUT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       fetch_req,
  output logic [7:0] fetch_addr,
  input  logic       fetch_valid,
  input  logic [7:0] fetch_data,
  output logic       done,
  output logic       err,
  output logic [7:0] map_type,
  output logic [7:0] rank0_size,
  output logic [7:0] rank_end,
  output logic [7:0] timing_cfg,
  output logic [7:0] clk_sel
);
  localparam int IW = $clog2(NBYTES);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_QUANT, S_FIN} state_t;
  state_t state;

  logic          accept, f_fin, f_tmo, wr_en, q_go, q_done;
  logic [IW-1:0] wr_idx;
  logic [7:0]    wr_data;
  logic [7:0]    desc [NBYTES];
  logic [7:0]    ref_w, size_w;
  logic [1:0]    c_trp, c_trcd, c_tras, cas_w;

  assign accept = start && (state == S_IDLE || state == S_FIN);
  assign q_go   = (state == S_FETCH) && f_fin;

  spd_fetch_seq #(.NB(NBYTES), .TIMEOUT(TIMEOUT)) u_fetch (
    .clk(clk), .rst_n(rst_n), .go(accept),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .fin(f_fin), .tmo(f_tmo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) desc[i] <= '0;
    end else if (wr_en) begin
      desc[wr_idx] <= wr_data;
    end
  end

  assign ref_w  = cycle_ref(desc[IX_TCK]);
  assign cas_w  = cas_code(desc[IX_CL], desc[IX_TCK2], desc[IX_TCK3], ref_w);
  assign size_w = dens_size(desc[IX_DENS]);

  spd_quantizer u_quant (
    .clk(clk), .rst_n(rst_n), .go(q_go), .ref_val(ref_w),
    .v_trp(desc[IX_TRP]), .v_trcd(desc[IX_TRCD]), .v_tras(desc[IX_TRAS]),
    .c_trp(c_trp), .c_trcd(c_trcd), .c_tras(c_tras), .q_done(q_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      done       <= 1'b0;
      err        <= 1'b0;
      map_type   <= 8'h00;
      rank0_size <= 8'h01;
      rank_end   <= 8'h01;
      timing_cfg <= 8'h00;
      clk_sel    <= 8'h80;
    end else if (accept) begin
      state      <= S_FETCH;
      done       <= 1'b0;
      err        <= 1'b0;
      map_type   <= 8'h00;
      rank0_size <= 8'h01;
      rank_end   <= 8'h01;
      timing_cfg <= 8'h00;
      clk_sel    <= 8'h80;
    end else begin
      case (state)
        S_FETCH: begin
          if (f_tmo) begin
            state <= S_FIN;
            done  <= 1'b1;
            err   <= 1'b1;
          end else if (f_fin) begin
            state <= S_QUANT;
          end
        end
        S_QUANT: begin
          if (q_done) begin
            state      <= S_FIN;
            done       <= 1'b1;
            map_type   <= map_code(desc[IX_BANKS], desc[IX_ROWS], desc[IX_WIDTH], desc[IX_COLS]);
            rank0_size <= size_w;
            rank_end   <= (desc[IX_RANKS] == 8'd2) ? (size_w << 1) : size_w;
            timing_cfg <= {c_tras, cas_w, c_trcd, c_trp};
            clk_sel    <= clock_code(desc[IX_TCK]);
          end
        end
        default: ;
      endcase
    end
  end

  p_err_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done && timing_cfg == 8'h00 && clk_sel == 8'h80 && map_type == 8'h00);

  p_cas_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> timing_cfg[5:4] != 2'd0);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(timing_cfg) && $stable(rank_end));

  p_rank_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> rank_end == rank0_size || rank_end == (rank0_size << 1));

  p_no_req_when_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !fetch_req);
endmodule

// File: tb/spd_timing_decoder_test.sv
module spd_timing_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic fetch_req, done, err;
  logic [7:0] fetch_addr, map_type, rank0_size, rank_end, timing_cfg, clk_sel;
  logic fetch_valid = 1'b0;
  logic [7:0] fetch_data = 8'h00;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  logic [7:0] mem [32];
  logic resp_en = 1'b1;
  int resp_delay = 0;
  int wait_cnt = 0;
  logic [7:0] log_a [16];
  int log_n = 0;
  logic [31:0] rs = 32'h1234_5678;

  spd_timing_decoder #(.TIMEOUT(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .done(done), .err(err), .map_type(map_type), .rank0_size(rank0_size),
    .rank_end(rank_end), .timing_cfg(timing_cfg), .clk_sel(clk_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: actual hung, expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // byte-fetch responder with programmable latency
  always @(negedge clk) begin
    if (!resp_en || !fetch_req) begin
      fetch_valid <= 1'b0;
      wait_cnt <= 0;
    end else if (fetch_valid) begin
      fetch_valid <= 1'b0;
      wait_cnt <= 0;
    end else if (wait_cnt >= resp_delay) begin
      fetch_valid <= 1'b1;
      fetch_data  <= mem[fetch_addr[4:0]];
      if (log_n < 16) log_a[log_n] <= fetch_addr;
      log_n <= log_n + 1;
    end else begin
      wait_cnt <= wait_cnt + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests = tests + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic int e_ref(input int t);
    return (t > 96) ? 30 : (t > 80) ? 24 : 20;
  endfunction

  function automatic int e_clk(input int t);
    return (t > 96) ? 'h80 : (t > 80) ? 'h81 : 'h85;
  endfunction

  function automatic int e_cas(input int cl, input int t2, input int t3, input int r);
    int c;
    if ((cl & 16) != 0) begin
      c = 3;
      if ((cl & 8) != 0 && t2 <= r) c = 2;
      if ((cl & 4) != 0 && t3 <= r) c = 1;
    end else begin
      c = ((cl & 4) != 0 && t2 <= r) ? 1 : 2;
    end
    return c;
  endfunction

  function automatic int e_q(input int v, input int r, input int lo);
    for (int c = 3; c >= 1; c--)
      if (v >= r * (lo + c - 1)) return c;
    return 0;
  endfunction

  function automatic int e_size(input int d);
    int pb [7] = '{1, 0, 7, 6, 5, 4, 3};
    for (int j = 0; j < 7; j++)
      if (((d >> pb[j]) & 1) != 0) return 64 >> j;
    return 1;
  endfunction

  function automatic int e_map(input int bk, input int rw, input int wd, input int cl);
    int m = 0;
    if (bk != 4) return 0;
    if (rw >= 13 && wd != 4) m = 128;
    if (cl == 10 || cl == 11 || cl == 12) m += 96;
    if (cl == 9) m += 64;
    if (cl == 8) m += 32;
    return m;
  endfunction

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(output int ok);
    int n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    ok = done ? 1 : 0;
  endtask

  task automatic run_case(input int extra_start);
    int ok, r, exp_t, exp_sz;
    int order [13] = '{9, 18, 23, 25, 27, 29, 30, 17, 3, 13, 4, 31, 5};
    int bad;
    log_n = 0;
    pulse_start();
    if (extra_start != 0) begin
      repeat (6) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    wait_done(ok);
    chk("R11 done raised", ok, 1);
    chk("R10 no err on answered run", int'(err), 0);
    r = e_ref(mem[9]);
    chk("R1 clock code", clk_sel, e_clk(mem[9]));
    exp_t = (e_q(mem[30], r, 7) << 6) | (e_cas(mem[18], mem[23], mem[25], r) << 4)
          | (e_q(mem[29], r, 3) << 2) | e_q(mem[27], r, 3);
    chk((mem[18] & 16) != 0 ? "R2 R4 R5 timing" : "R3 R4 R5 timing", timing_cfg, exp_t);
    chk("R6 map", map_type, e_map(mem[17], mem[3], mem[13], mem[4]));
    exp_sz = e_size(mem[31]);
    chk("R7 rank size", rank0_size, exp_sz);
    chk("R8 rank end", rank_end, (mem[5] == 2) ? exp_sz * 2 : exp_sz);
    bad = (log_n != 13) ? 1 : 0;
    for (int i = 0; i < 13 && i < log_n; i++) if (log_a[i] != 8'(order[i])) bad = 1;
    chk("R9 R11 fetch order", bad, 0);
  endtask

  function automatic int sat(input int v);
    return (v > 255) ? 255 : (v < 0) ? 0 : v;
  endfunction

  initial begin
    int tcks [7] = '{'h3C, 'h50, 'h51, 'h60, 'h61, 'h75, 'hA0};
    int r, ok, t0, held;
    for (int i = 0; i < 32; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 reset done", int'(done), 0);
    chk("R11 reset err", int'(err), 0);
    chk("R11 reset req", int'(fetch_req), 0);
    chk("R11 reset timing", timing_cfg, 0);
    chk("R11 reset clk", clk_sel, 'h80);
    chk("R11 reset rank", rank0_size, 1);

    for (int it = 0; it < 90; it++) begin
      rs = nxt(rs);
      mem[9] = 8'(tcks[rs % 7]);
      r = e_ref(mem[9]);
      rs = nxt(rs); mem[18] = 8'(rs & 32'h1C);
      rs = nxt(rs); mem[23] = 8'(sat(r - 1 + int'(rs % 3)));
      rs = nxt(rs); mem[25] = 8'(sat(r - 1 + int'(rs % 3)));
      rs = nxt(rs); mem[27] = 8'(sat(r * (2 + int'(rs % 5)) - int'((rs >> 8) & 1)));
      rs = nxt(rs); mem[29] = 8'(sat(r * (2 + int'(rs % 5)) - int'((rs >> 8) & 1)));
      rs = nxt(rs); mem[30] = 8'(sat(r * (6 + int'(rs % 4)) - int'((rs >> 8) & 1)));
      rs = nxt(rs); mem[17] = ((rs & 3) == 0) ? 8'd2 : 8'd4;
      rs = nxt(rs); mem[3]  = 8'(11 + rs % 4);
      rs = nxt(rs); mem[13] = ((rs % 3) == 0) ? 8'd4 : ((rs % 3) == 1) ? 8'd8 : 8'd16;
      rs = nxt(rs); mem[4]  = 8'(7 + rs % 7);
      rs = nxt(rs);
      if (it < 9) mem[31] = (it == 8) ? 8'h00 : 8'(1 << it);
      else mem[31] = 8'(rs >> 5);
      rs = nxt(rs); mem[5] = 8'(1 + rs % 2);
      resp_delay = it % 4;
      run_case((it % 10) == 3 ? 1 : 0);
    end

    // R11 hold
    t0 = timing_cfg;
    repeat (5) @(negedge clk);
    held = (done && timing_cfg == t0) ? 1 : 0;
    chk("R11 outputs held", held, 1);

    // R10 timeout: no answers
    resp_en = 1'b0;
    pulse_start();
    wait_done(ok);
    chk("R10 timeout done", ok, 1);
    chk("R10 timeout err", int'(err), 1);
    chk("R10 timeout req low", int'(fetch_req), 0);
    chk("R10 default timing", timing_cfg, 0);
    chk("R10 default clk", clk_sel, 'h80);
    chk("R10 default map", map_type, 0);
    chk("R10 default rank", rank0_size, 1);
    chk("R10 default end", rank_end, 1);

    // recovery with a boundary descriptor
    resp_en = 1'b1;
    resp_delay = 1;
    mem[9] = 8'h50; mem[18] = 8'h1C; mem[23] = 8'h14; mem[25] = 8'h15;
    mem[27] = 8'd100; mem[29] = 8'd79; mem[30] = 8'd140;
    mem[17] = 8'd4; mem[3] = 8'd13; mem[13] = 8'd8; mem[4] = 8'd10;
    mem[31] = 8'h03; mem[5] = 8'd2;
    run_case(0);
    chk("R4 boundary 5x trp", timing_cfg[1:0], 3);
    chk("R4 boundary below 4x trcd", timing_cfg[3:2], 1);
    chk("R5 boundary 7x tras", timing_cfg[7:6], 1);
    chk("R2 cas 2.5 chosen", timing_cfg[5:4], 2);
    chk("R7 priority bit1 over bit0", rank0_size, 'h40);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule